// File: doc/BRIEF.md
# Dual-Channel DAC Sample Formatter

This block takes sample words from two 16-bit parallel input buses and turns them into aligned, signed A and B channel samples for a downstream interpolation path. Three input arrangements are supported. In separate mode each bus carries its own channel. In interleaved mode A and B words alternate on the A bus alone. In half-rate mode both buses carry consecutive channel-A samples, which are issued one after the other.

Each bus can have its bit order reversed. Words are read either as two's complement or as offset binary, and offset-binary words are converted to signed form. Channel B can be negated, with saturation, to move the output to the upper sideband. A four-entry elastic FIFO sits between the pairing logic and the output and can be bypassed. A separate bypass-all path forwards the raw buses untouched.

The input mode is sampled only while the synchronous clear is high. Clearing also empties the FIFO, the pairing state and the sticky error flags. All other configuration inputs are static levels that apply directly.

Top module: `dacfmt_top`

## Requirements
- R1: After reset, `out_valid`, `ovf_flag` and `unf_flag` are 0.
- R2: In separate mode (`mode_sel`=2'b00) with the FIFO bypassed, a valid input cycle produces one output pair (A from `bus_a`, B from `bus_b`), and `out_valid` rises in the second cycle after the input cycle.
- R3: In interleaved mode (`mode_sel`=2'b01) with `cfg_flag_sel`=1, a word on `bus_a` with `b_mark`=0 is held as the A sample; a later word with `b_mark`=1 is emitted as B together with the most recently held A. A marked word with no A held is dropped.
- R4: In interleaved mode with `cfg_flag_sel`=0, the first valid word in or after the cycle in which `tx_en` rises is an A sample; after that, valid words alternate A, B, and each B word emits a pair.
- R5: In half-rate mode (`mode_sel`=2'b10), a valid cycle yields two A outputs on consecutive cycles: first the `bus_a` sample, then the `bus_b` sample, each with `out_b`=0. A valid input in the cycle right after such a cycle is ignored.
- R6: With `cfg_rev_a` (or `cfg_rev_b`) set, bit 15 of that bus becomes the LSB and bit 0 the MSB before any other processing.
- R7: With `cfg_twos`=1 words pass unchanged; with `cfg_twos`=0 the MSB of the (possibly reversed) word is inverted.
- R8: With `cfg_neg_b`=1 the B channel is negated after format conversion, and 16'h8000 becomes 16'h7FFF.
- R9: With `cfg_fifo_bypass`=0, pairs enter a 4-entry FIFO. `rd_en` on a non-empty FIFO presents the oldest pair on the next cycle with `out_valid`=1.
- R10: A pair arriving at a full FIFO with no read is dropped and sets `ovf_flag`. `rd_en` on an empty FIFO sets `unf_flag`. Both flags stay set until `sync_clr`.
- R11: With `cfg_bypass_all`=1, a valid cycle drives the raw `bus_a` and `bus_b` to `out_a` and `out_b` on the next cycle, with no reversal, conversion or negation.
- R12: `mode_sel` is sampled only in a cycle with `sync_clr`=1 (separate mode after reset). `sync_clr` also empties the FIFO, clears the pairing state and `out_valid`, and clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr | input | 1 | Synchronous clear; samples the mode |
| mode_sel | input | 2 | 00 separate, 01 interleaved, 10 half-rate, 11 as separate |
| cfg_flag_sel | input | 1 | Interleave phase source: 1 = `b_mark`, 0 = `tx_en` rising edge |
| cfg_twos | input | 1 | 1 = two's complement input, 0 = offset binary |
| cfg_rev_a | input | 1 | Reverse bit order of `bus_a` |
| cfg_rev_b | input | 1 | Reverse bit order of `bus_b` |
| cfg_neg_b | input | 1 | Negate channel B with saturation |
| cfg_fifo_bypass | input | 1 | 1 = FIFO bypassed |
| cfg_bypass_all | input | 1 | 1 = raw buses forwarded |
| in_valid | input | 1 | Input word strobe |
| bus_a | input | 16 | Input bus A |
| bus_b | input | 16 | Input bus B |
| b_mark | input | 1 | Marks a B word in interleaved mode |
| tx_en | input | 1 | Transmit enable; its rising edge sets the interleave phase |
| rd_en | input | 1 | FIFO read request |
| out_valid | output | 1 | Output pair strobe |
| out_a | output | 16 | Channel A sample |
| out_b | output | 16 | Channel B sample |
| ovf_flag | output | 1 | Sticky FIFO overflow |
| unf_flag | output | 1 | Sticky FIFO underflow |

## Verification
The hardest situations to reach are the phase corner cases of interleaved data. Examples are a `tx_en` rising edge that arrives while an A word is held, so the phase must restart and the held word is abandoned, and a half-rate word that arrives in the slot taken by the pending second sample. Random runs in each mode toggle `tx_en` and `in_valid` independently, so both cases occur often, and a reference model in the bench tracks the phase. Directed sequences then force a mid-stream edge, an orphan B marker and the 16'h8000 negation case. FIFO overflow and underflow are reached by withholding reads during a burst and by reading an empty FIFO.

// File: rtl/dacfmt_pkg.sv
package dacfmt_pkg;
  typedef enum logic [1:0] {
    FMT_SEP  = 2'b00,
    FMT_ILV  = 2'b01,
    FMT_HALF = 2'b10,
    FMT_RSVD = 2'b11
  } fmt_mode_e;
endpackage

// File: rtl/dacfmt_word_conv.sv
module dacfmt_word_conv #(
  parameter int W = 16
) (
  input  logic [W-1:0] raw,
  input  logic         rev,
  input  logic         twos,
  output logic [W-1:0] word
);
  logic [W-1:0] flipped;
  logic [W-1:0] ordered;

  for (genvar g = 0; g < W; g++) begin : g_flip
    assign flipped[g] = raw[W-1-g];
  end

  always_comb begin
    ordered = rev ? flipped : raw;
    if (twos) word = ordered;
    else      word = {~ordered[W-1], ordered[W-2:0]};
  end
endmodule

// File: rtl/dacfmt_pairer.sv
module dacfmt_pairer
  import dacfmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  fmt_mode_e    mode,
  input  logic         flag_sel,
  input  logic         neg_b,
  input  logic         in_valid,
  input  logic [W-1:0] word_a,
  input  logic [W-1:0] word_b,
  input  logic         b_mark,
  input  logic         tx_en,
  output logic         pair_v,
  output logic [W-1:0] pair_a,
  output logic [W-1:0] pair_b
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] sat_neg(input logic [W-1:0] x);
    if (x == MOST_NEG) return MOST_POS;
    return ~x + ONE;
  endfunction

  logic         have_a, have_a_n;
  logic         phase_b, phase_b_n;
  logic         pend_v, pend_v_n;
  logic         tx_q;
  logic [W-1:0] held, pend;
  logic         held_ld, pend_ld;
  logic         emit;
  logic [W-1:0] emit_a, emit_b, b_fin;
  logic         tx_rise, eff_b;

  always_comb begin
    tx_rise   = tx_en & ~tx_q;
    eff_b     = phase_b & ~tx_rise;
    have_a_n  = have_a;
    phase_b_n = phase_b;
    pend_v_n  = pend_v;
    held_ld   = 1'b0;
    pend_ld   = 1'b0;
    emit      = 1'b0;
    emit_a    = word_a;
    emit_b    = word_b;
    unique case (mode)
      FMT_ILV: begin
        emit_a = held;
        emit_b = word_a;
        if (flag_sel) begin
          if (in_valid && b_mark) begin
            emit     = have_a;
            have_a_n = 1'b0;
          end else if (in_valid) begin
            held_ld  = 1'b1;
            have_a_n = 1'b1;
          end
        end else begin
          if (in_valid && !eff_b) begin
            held_ld   = 1'b1;
            phase_b_n = 1'b1;
          end else if (in_valid) begin
            emit      = 1'b1;
            phase_b_n = 1'b0;
          end else if (tx_rise) begin
            phase_b_n = 1'b0;
          end
        end
      end
      FMT_HALF: begin
        emit_b = '0;
        if (pend_v) begin
          emit     = 1'b1;
          emit_a   = pend;
          pend_v_n = 1'b0;
        end else if (in_valid) begin
          emit     = 1'b1;
          pend_ld  = 1'b1;
          pend_v_n = 1'b1;
        end
      end
      default: begin
        emit = in_valid;
      end
    endcase
    b_fin = neg_b ? sat_neg(emit_b) : emit_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_a  <= 1'b0;
      phase_b <= 1'b0;
      pend_v  <= 1'b0;
      pair_v  <= 1'b0;
      tx_q    <= 1'b0;
    end else begin
      tx_q <= tx_en;
      if (clr) begin
        have_a  <= 1'b0;
        phase_b <= 1'b0;
        pend_v  <= 1'b0;
        pair_v  <= 1'b0;
      end else begin
        have_a  <= have_a_n;
        phase_b <= phase_b_n;
        pend_v  <= pend_v_n;
        pair_v  <= emit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (held_ld) held <= word_a;
    if (pend_ld) pend <= word_b;
    if (emit) begin
      pair_a <= emit_a;
      pair_b <= b_fin;
    end
  end
endmodule

// File: rtl/dacfmt_fifo.sv
module dacfmt_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          rd,
  output logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] cnt,
  output logic          ovf,
  output logic          unf
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp, wp_n, rp_n;
  logic [CW-1:0] cnt_n;
  logic          full, empty, wr;
  logic          ovf_n, unf_n;

  always_comb begin
    full  = (cnt == FULL_CNT);
    empty = (cnt == '0);
    pop   = rd && !empty;
    wr    = push && (!full || pop);
    wp_n  = wp;
    rp_n  = rp;
    if (wr)  wp_n = (wp == LAST) ? '0 : wp + AW'(1);
    if (pop) rp_n = (rp == LAST) ? '0 : rp + AW'(1);
    cnt_n = cnt;
    if (wr && !pop)      cnt_n = cnt + CW'(1);
    else if (pop && !wr) cnt_n = cnt - CW'(1);
    ovf_n = ovf | (push && !wr);
    unf_n = unf | (rd && empty);
    dout  = mem[rp];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      wp  <= wp_n;
      rp  <= rp_n;
      cnt <= cnt_n;
      ovf <= ovf_n;
      unf <= unf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= din;
  end
endmodule

// File: rtl/dacfmt_top.sv
module dacfmt_top
  import dacfmt_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int CW   = ((DEPTH > 1) ? $clog2(DEPTH) : 1) + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sync_clr,
  input  logic [1:0]   mode_sel,
  input  logic         cfg_flag_sel,
  input  logic         cfg_twos,
  input  logic         cfg_rev_a,
  input  logic         cfg_rev_b,
  input  logic         cfg_neg_b,
  input  logic         cfg_fifo_bypass,
  input  logic         cfg_bypass_all,
  input  logic         in_valid,
  input  logic [W-1:0] bus_a,
  input  logic [W-1:0] bus_b,
  input  logic         b_mark,
  input  logic         tx_en,
  input  logic         rd_en,
  output logic         out_valid,
  output logic [W-1:0] out_a,
  output logic [W-1:0] out_b,
  output logic         ovf_flag,
  output logic         unf_flag
);
  fmt_mode_e    mode_q;
  logic [W-1:0] raw_w  [2];
  logic [W-1:0] conv_w [2];
  logic         rev_w  [2];
  logic         pair_v;
  logic [W-1:0] pair_a, pair_b;
  logic         fifo_en, f_push, f_rd, f_pop;
  logic [2*W-1:0] f_dout;
  logic [CW-1:0]  fifo_cnt;
  logic         ov_n;
  logic [W-1:0] oa_n, ob_n;

  assign raw_w[0] = bus_a;
  assign raw_w[1] = bus_b;
  assign rev_w[0] = cfg_rev_a;
  assign rev_w[1] = cfg_rev_b;

  for (genvar c = 0; c < 2; c++) begin : g_conv
    dacfmt_word_conv #(.W(W)) u_conv (
      .raw  (raw_w[c]),
      .rev  (rev_w[c]),
      .twos (cfg_twos),
      .word (conv_w[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_q <= FMT_SEP;
    else if (sync_clr) mode_q <= fmt_mode_e'(mode_sel);
  end

  dacfmt_pairer #(.W(W)) u_pair (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (sync_clr),
    .mode     (mode_q),
    .flag_sel (cfg_flag_sel),
    .neg_b    (cfg_neg_b),
    .in_valid (in_valid && !cfg_bypass_all),
    .word_a   (conv_w[0]),
    .word_b   (conv_w[1]),
    .b_mark   (b_mark),
    .tx_en    (tx_en),
    .pair_v   (pair_v),
    .pair_a   (pair_a),
    .pair_b   (pair_b)
  );

  assign fifo_en = !cfg_fifo_bypass && !cfg_bypass_all;
  assign f_push  = fifo_en && pair_v;
  assign f_rd    = fifo_en && rd_en;

  dacfmt_fifo #(.DW(2*W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (sync_clr),
    .push  (f_push),
    .din   ({pair_a, pair_b}),
    .rd    (f_rd),
    .pop   (f_pop),
    .dout  (f_dout),
    .cnt   (fifo_cnt),
    .ovf   (ovf_flag),
    .unf   (unf_flag)
  );

  always_comb begin
    if (cfg_bypass_all) begin
      ov_n = in_valid;
      oa_n = bus_a;
      ob_n = bus_b;
    end else if (cfg_fifo_bypass) begin
      ov_n = pair_v;
      oa_n = pair_a;
      ob_n = pair_b;
    end else begin
      ov_n = f_pop;
      oa_n = f_dout[2*W-1:W];
      ob_n = f_dout[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_valid <= 1'b0;
    else if (sync_clr) out_valid <= 1'b0;
    else               out_valid <= ov_n;
  end

  always_ff @(posedge clk) begin
    if (ov_n) begin
      out_a <= oa_n;
      out_b <= ob_n;
    end
  end
endmodule

// File: rtl/dacfmt_checker.sv
module dacfmt_checker
  import dacfmt_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int CW   = ((DEPTH > 1) ? $clog2(DEPTH) : 1) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_clr,
  input logic          in_valid,
  input logic [W-1:0]  bus_a,
  input logic          cfg_bypass_all,
  input logic          cfg_fifo_bypass,
  input logic          rd_en,
  input logic          out_valid,
  input logic [W-1:0]  out_a,
  input logic [W-1:0]  out_b,
  input logic          ovf_flag,
  input logic          unf_flag,
  input fmt_mode_e     mode_q,
  input logic [CW-1:0] fifo_cnt
);
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !sync_clr |=> ovf_flag);

  p_unf_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_clr && !cfg_bypass_all && !cfg_fifo_bypass && rd_en && fifo_cnt == '0
    |=> unf_flag);

  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> !ovf_flag && !unf_flag && !out_valid);

  p_raw_path_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bypass_all && in_valid && !sync_clr |=> out_valid && out_a == $past(bus_a));

  p_half_b_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode_q == FMT_HALF && !$past(cfg_bypass_all) |-> out_b == '0);
endmodule

bind dacfmt_top dacfmt_checker #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .sync_clr        (sync_clr),
  .in_valid        (in_valid),
  .bus_a           (bus_a),
  .cfg_bypass_all  (cfg_bypass_all),
  .cfg_fifo_bypass (cfg_fifo_bypass),
  .rd_en           (rd_en),
  .out_valid       (out_valid),
  .out_a           (out_a),
  .out_b           (out_b),
  .ovf_flag        (ovf_flag),
  .unf_flag        (unf_flag),
  .mode_q          (mode_q),
  .fifo_cnt        (fifo_cnt)
);

// File: tb/dacfmt_top_bench.sv
module dacfmt_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sync_clr;
  logic [1:0]  mode_sel;
  logic        cfg_flag_sel, cfg_twos, cfg_rev_a, cfg_rev_b, cfg_neg_b;
  logic        cfg_fifo_bypass, cfg_bypass_all;
  logic        in_valid, b_mark, tx_en, rd_en;
  logic [15:0] bus_a, bus_b;
  logic        out_valid, ovf_flag, unf_flag;
  logic [15:0] out_a, out_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [1:0]  m_mode;
  logic        m_have, m_phase, m_skip, m_prev_tx;
  logic [15:0] m_held;

  always #4 clk = ~clk;

  dacfmt_top u_dacfmt_top (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .mode_sel(mode_sel),
    .cfg_flag_sel(cfg_flag_sel), .cfg_twos(cfg_twos), .cfg_rev_a(cfg_rev_a),
    .cfg_rev_b(cfg_rev_b), .cfg_neg_b(cfg_neg_b), .cfg_fifo_bypass(cfg_fifo_bypass),
    .cfg_bypass_all(cfg_bypass_all), .in_valid(in_valid), .bus_a(bus_a), .bus_b(bus_b),
    .b_mark(b_mark), .tx_en(tx_en), .rd_en(rd_en), .out_valid(out_valid),
    .out_a(out_a), .out_b(out_b), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  function automatic logic [15:0] m_rev(input logic [15:0] x);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = x[15-i];
    return r;
  endfunction

  function automatic logic [15:0] m_conv(input logic [15:0] x, input logic rv, input logic tw);
    logic [15:0] o = rv ? m_rev(x) : x;
    return tw ? o : (o ^ 16'h8000);
  endfunction

  function automatic logic [15:0] m_neg(input logic [15:0] x, input logic en);
    if (!en) return x;
    if (x == 16'h8000) return 16'h7fff;
    return 16'h0000 - x;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic expect_pair(input logic [15:0] a, input logic [15:0] b, input string tag);
    exp_q.push_back({a, b});
    tag_q.push_back(tag);
  endtask

  task automatic model_step(input logic v, input logic [15:0] a, input logic [15:0] b,
                            input logic mk, input logic tx, input string tag);
    logic [15:0] ca = m_conv(a, cfg_rev_a, cfg_twos);
    logic [15:0] cb = m_conv(b, cfg_rev_b, cfg_twos);
    logic rise = tx && !m_prev_tx;
    logic ph;
    m_prev_tx = tx;
    if (cfg_bypass_all) begin
      if (v) expect_pair(a, b, tag);
    end else if (m_mode == 2'b01 && cfg_flag_sel) begin
      if (v && mk) begin
        if (m_have) expect_pair(m_held, m_neg(ca, cfg_neg_b), tag);
        m_have = 0;
      end else if (v) begin
        m_held = ca;
        m_have = 1;
      end
    end else if (m_mode == 2'b01) begin
      ph = m_phase && !rise;
      if (v && !ph) begin
        m_held = ca;
        m_phase = 1;
      end else if (v) begin
        expect_pair(m_held, m_neg(ca, cfg_neg_b), tag);
        m_phase = 0;
      end else if (rise) m_phase = 0;
    end else if (m_mode == 2'b10) begin
      if (m_skip) m_skip = 0;
      else if (v) begin
        expect_pair(ca, 16'h0000, tag);
        expect_pair(cb, 16'h0000, tag);
        m_skip = 1;
      end
    end else begin
      if (v) expect_pair(ca, m_neg(cb, cfg_neg_b), tag);
    end
  endtask

  task automatic drive(input logic v, input logic [15:0] a, input logic [15:0] b,
                       input logic mk, input logic tx, input logic rd, input string tag);
    in_valid = v; bus_a = a; bus_b = b; b_mark = mk; tx_en = tx; rd_en = rd;
    model_step(v, a, b, mk, tx, tag);
    @(posedge clk);
    #1;
    in_valid = 0; rd_en = 0; b_mark = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 16'h0, 16'h0, 0, tx_en, 0, "idle");
  endtask

  task automatic sync_pulse(input logic [1:0] md);
    mode_sel = md;
    sync_clr = 1;
    m_prev_tx = tx_en;
    @(posedge clk);
    #1;
    sync_clr = 0;
    m_mode = md; m_have = 0; m_phase = 0; m_skip = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2 unexpected output actual=%h expected=none", {out_a, out_b});
      end else begin
        chk(tag_q.pop_front(), {out_a, out_b}, exp_q.pop_front());
      end
    end
  end

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  task automatic rand_phase(input logic [1:0] md, input logic fs, input int n, input string tag);
    cfg_rev_a = 1'($urandom); cfg_rev_b = 1'($urandom);
    cfg_twos = 1'($urandom);  cfg_neg_b = 1'($urandom);
    cfg_flag_sel = fs;
    sync_pulse(md);
    for (int i = 0; i < n; i++) begin
      logic t = ($urandom % 12 == 0) ? ~tx_en : tx_en;
      drive(1'($urandom), 16'($urandom), 16'($urandom), 1'($urandom), t, 0, tag);
    end
    idle(6);
    chk({tag, " drained"}, exp_q.size(), 0);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h1d5a);
    rst_n = 0; sync_clr = 0; mode_sel = 2'b00; cfg_flag_sel = 0; cfg_twos = 1;
    cfg_rev_a = 0; cfg_rev_b = 0; cfg_neg_b = 0; cfg_fifo_bypass = 1; cfg_bypass_all = 0;
    in_valid = 0; bus_a = 0; bus_b = 0; b_mark = 0; tx_en = 0; rd_en = 0;
    m_mode = 2'b00; m_have = 0; m_phase = 0; m_skip = 0; m_prev_tx = 0; m_held = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(2);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 unf", unf_flag, 0);

    // R2 latency in separate mode
    drive(1, 16'h1234, 16'h5678, 0, 0, 0, "R2");
    chk("R2 not yet valid", out_valid, 0);
    idle(1);
    chk("R2 valid two cycles later", out_valid, 1);
    idle(2);

    // R6, R7, R8 conversions
    cfg_rev_a = 1; cfg_twos = 1;
    drive(1, 16'h0001, 16'h0003, 0, 0, 0, "R6");
    idle(3);
    chk("R6 reversed A", out_a, 16'h8000);
    cfg_rev_a = 0; cfg_twos = 0;
    drive(1, 16'h0000, 16'hffff, 0, 0, 0, "R7");
    idle(3);
    chk("R7 offset A", out_a, 16'h8000);
    cfg_twos = 1; cfg_neg_b = 1;
    drive(1, 16'h0005, 16'h8000, 0, 0, 0, "R8");
    idle(3);
    chk("R8 saturated B", out_b, 16'h7fff);
    cfg_neg_b = 0;

    // R12 mode change without clear has no effect
    mode_sel = 2'b10;
    drive(1, 16'h0aaa, 16'h0bbb, 0, 0, 0, "R12");
    idle(3);
    chk("R12 still separate", out_b, 16'h0bbb);

    // R3 marker pairing
    cfg_flag_sel = 1;
    sync_pulse(2'b01);
    drive(1, 16'h0100, 0, 1, 0, 0, "R3");
    drive(1, 16'h0200, 0, 0, 0, 0, "R3");
    drive(1, 16'h0300, 0, 0, 0, 0, "R3");
    drive(1, 16'h0400, 0, 1, 0, 0, "R3");
    idle(3);
    chk("R3 pair A", out_a, 16'h0300);
    chk("R3 pair B", out_b, 16'h0400);
    chk("R3 drained", exp_q.size(), 0);

    // R4 transmit-enable phase
    cfg_flag_sel = 0;
    sync_pulse(2'b01);
    drive(1, 16'h0011, 0, 0, 1, 0, "R4");
    drive(1, 16'h0022, 0, 0, 1, 0, "R4");
    drive(1, 16'h0033, 0, 0, 1, 0, "R4");
    drive(0, 16'h0000, 0, 0, 0, 0, "R4");
    drive(1, 16'h0044, 0, 0, 1, 0, "R4");
    drive(1, 16'h0055, 0, 0, 1, 0, "R4");
    idle(3);
    chk("R4 restarted A", out_a, 16'h0044);
    chk("R4 drained", exp_q.size(), 0);

    // R5 half rate, second slot ignored
    sync_pulse(2'b10);
    drive(1, 16'h0101, 16'h0202, 0, 1, 0, "R5");
    drive(1, 16'h0303, 16'h0404, 0, 1, 0, "R5");
    idle(4);
    chk("R5 second sample", out_a, 16'h0202);
    chk("R5 ignored slot", exp_q.size(), 0);

    // R9, R10 FIFO
    cfg_fifo_bypass = 0;
    sync_pulse(2'b00);
    drive(1, 16'h1001, 16'h2001, 0, 1, 0, "R9");
    drive(1, 16'h1002, 16'h2002, 0, 1, 0, "R9");
    drive(1, 16'h1003, 16'h2003, 0, 1, 0, "R9");
    idle(3);
    chk("R9 held until read", out_valid, 0);
    for (int i = 0; i < 3; i++) drive(0, 0, 0, 0, 1, 1, "R9");
    idle(2);
    chk("R9 drained", exp_q.size(), 0);
    chk("R10 no underflow yet", unf_flag, 0);
    drive(0, 0, 0, 0, 1, 1, "R10");
    idle(1);
    chk("R10 underflow sticky", unf_flag, 1);
    for (int i = 0; i < 5; i++) drive(1, 16'h3000 + 16'(i), 16'h4000 + 16'(i), 0, 1, 0, "R10");
    idle(2);
    chk("R10 overflow", ovf_flag, 1);
    void'(exp_q.pop_back());
    void'(tag_q.pop_back());
    for (int i = 0; i < 4; i++) drive(0, 0, 0, 0, 1, 1, "R10");
    idle(2);
    chk("R10 dropped newest", exp_q.size(), 0);
    chk("R10 overflow kept", ovf_flag, 1);
    sync_pulse(2'b00);
    chk("R12 ovf cleared", ovf_flag, 0);
    chk("R12 unf cleared", unf_flag, 0);
    cfg_fifo_bypass = 1;

    // R11 bypass all
    cfg_bypass_all = 1; cfg_rev_a = 1; cfg_neg_b = 1; cfg_twos = 0;
    drive(1, 16'h1234, 16'h8000, 0, 1, 0, "R11");
    chk("R11 one cycle", out_valid, 1);
    chk("R11 raw B", out_b, 16'h8000);
    idle(2);
    cfg_bypass_all = 0;

    // random phases
    rand_phase(2'b00, 0, 300, "R2");
    rand_phase(2'b01, 1, 300, "R3");
    rand_phase(2'b01, 0, 300, "R4");
    rand_phase(2'b10, 0, 300, "R5");

    done = 1;
    summary();
    $finish;
  end
endmodule